// File: doc/BRIEF.md
# Multi-Port Shared Memory with Write-Collision Merging

This block is a small register-based shared memory that several requesting ports use in the same clock cycle. In every cycle, each port may read one word, write one word, or do both. Any number of ports may read the same word at once. When two or more ports write the same word in one cycle, a policy chosen at run time decides the outcome. The policy can require that all the values agree, pick one writer by rotation, pick the writer with the lowest index, or store the sum of all the values.

Each port gets a registered read-data lane and a registered write-success flag. Both lanes are valid in the cycle after the request. Callers use the flag to learn whether their write reached the memory and retry a failed write if they need to. The policy select is sampled every cycle, so successive cycles may use different policies.

Top module: `cwm_memory`

## Requirements
- R1: While reset is asserted and after it is released, every memory word reads as zero, every read-data lane is zero and every success flag is zero.
- R2: A port with its read enable high in cycle n shows that word's stored value on its read lane in cycle n+1. Several ports reading the same word all show the same value. With the read enable low, a read lane keeps its previous value.
- R3: A read and a write to the same word in the same cycle return the contents from before the write. The written value is visible to reads issued in the next cycle.
- R4: A write with no other writer to that word in its cycle always updates the word and reports success, under every policy.
- R5: Policy 0 (all-agree) updates a word hit by several writers, and flags all of them successful, only when all their values are equal. Otherwise the word keeps its contents and every one of those writers is flagged as failed.
- R6: Policy 1 (rotating) lets exactly one of the colliding writers succeed. The winner is the first colliding port found when scanning upward in index from a rotating pointer, wrapping at the top. The pointer is 0 after reset and advances by one, modulo the port count, after each policy-1 cycle in which some word has two or more writers.
- R7: Policy 2 (fixed rank) lets the colliding writer with the lowest port index succeed. All the other colliding writers fail.
- R8: Policy 3 (sum) stores the sum, modulo 2^WIDTH, of all the values written to the word in that cycle, and flags every writer successful.
- R9: Success flag bit i is high in cycle n+1 exactly when port i wrote in cycle n and its write succeeded. The flag is low for a port that did not write.
- R10: Writes to different words in the same cycle are resolved independently and all take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Collision policy: 0 all-agree, 1 rotating, 2 fixed rank, 3 sum |
| wr_en_i | input | NPORTS | Per-port write request |
| rd_en_i | input | NPORTS | Per-port read request |
| addr_i | input | NPORTS*AW | Per-port word address, port i in bits [i*AW +: AW] |
| wdata_i | input | NPORTS*WIDTH | Per-port write value, port i in bits [i*WIDTH +: WIDTH] |
| rdata_o | output | NPORTS*WIDTH | Per-port read lane, registered |
| wr_ok_o | output | NPORTS | Per-port write-success flag, registered |

## Verification
A merge error in the resolver shows in two ways. Its success flags are wrong one cycle after the colliding write. The stored word is wrong as soon as any port reads it, which the bench does right after most collision patterns. A rotating pointer that has drifted does not show in reads. It shows only at the next policy-1 collision, as the wrong port's flag going high. For that reason the bench issues chains of collisions back to back, with non-colliding cycles between them. A corrupted word in a part of the array that the test never touches would stay hidden until a final sweep reads every word.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

  typedef enum logic [1:0] {
    POL_AGREE  = 2'd0,
    POL_ROTATE = 2'd1,
    POL_RANK   = 2'd2,
    POL_SUM    = 2'd3
  } policy_e;

endpackage

// File: rtl/cwm_rr_ptr.sv
// Rotating start pointer for the rotating collision policy.
module cwm_rr_ptr #(
  parameter int NPORTS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;

  always_comb begin
    if (ptr_q == PW'(NPORTS - 1)) ptr_d = '0;
    else                          ptr_d = ptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/cwm_resolver.sv
// Combinational collision resolution: finds, for every writing port, the
// set of ports writing the same word, then decides success and which port
// commits the merged value for that word.
module cwm_resolver
  import cwm_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int AW     = 4,
  parameter int WIDTH  = 8,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  policy_e                   policy_i,
  input  logic [NPORTS-1:0]         we_i,
  input  logic [NPORTS*AW-1:0]      addr_i,
  input  logic [NPORTS*WIDTH-1:0]   wdata_i,
  input  logic [PW-1:0]             ptr_i,
  output logic [NPORTS-1:0]         commit_o,
  output logic [NPORTS*WIDTH-1:0]   cdata_o,
  output logic [NPORTS-1:0]         ok_o,
  output logic                      clash_o
);

  logic [NPORTS-1:0] multi;

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    localparam logic [NPORTS-1:0] SELF  = NPORTS'(1) << i;
    localparam logic [NPORTS-1:0] LOWER = SELF - NPORTS'(1);

    logic [NPORTS-1:0] grp;
    logic              lead;
    logic              agree;
    logic              rot_win;
    logic [WIDTH-1:0]  total;
    logic [PW-1:0]     my_dist;

    // ports (including this one) writing the same word as port i
    always_comb begin
      grp = '0;
      for (int j = 0; j < NPORTS; j++) begin
        grp[j] = we_i[i] && we_i[j] &&
                 (addr_i[j*AW +: AW] == addr_i[i*AW +: AW]);
      end
    end

    assign lead     = we_i[i] && ((grp & LOWER) == '0);
    assign multi[i] = we_i[i] && ((grp & ~SELF) != '0);
    assign my_dist  = PW'(i) - ptr_i;

    always_comb begin
      agree   = we_i[i];
      total   = '0;
      rot_win = we_i[i];
      for (int j = 0; j < NPORTS; j++) begin
        if (grp[j]) begin
          total = total + wdata_i[j*WIDTH +: WIDTH];
          if (wdata_i[j*WIDTH +: WIDTH] != wdata_i[i*WIDTH +: WIDTH])
            agree = 1'b0;
          if ((j != i) && ((PW'(j) - ptr_i) < my_dist))
            rot_win = 1'b0;
        end
      end
    end

    always_comb begin
      unique case (policy_i)
        POL_AGREE: begin
          ok_o[i]     = agree;
          commit_o[i] = lead && agree;
        end
        POL_ROTATE: begin
          ok_o[i]     = rot_win;
          commit_o[i] = rot_win;
        end
        POL_RANK: begin
          ok_o[i]     = lead;
          commit_o[i] = lead;
        end
        default: begin
          ok_o[i]     = we_i[i];
          commit_o[i] = lead;
        end
      endcase
    end

    assign cdata_o[i*WIDTH +: WIDTH] =
      (policy_i == POL_SUM) ? total : wdata_i[i*WIDTH +: WIDTH];
  end

  assign clash_o = |multi;

endmodule

// File: rtl/cwm_store.sv
// Word array with one resolved write per word and registered read lanes.
module cwm_store #(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORTS-1:0]         commit_i,
  input  logic [NPORTS*AW-1:0]      waddr_i,
  input  logic [NPORTS*WIDTH-1:0]   cdata_i,
  input  logic [NPORTS-1:0]         re_i,
  input  logic [NPORTS*AW-1:0]      raddr_i,
  output logic [NPORTS*WIDTH-1:0]   rdata_o
);

  logic [DEPTH*WIDTH-1:0] words;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic             hit;
    logic [WIDTH-1:0] val;
    logic [WIDTH-1:0] word_q;

    always_comb begin
      hit = 1'b0;
      val = '0;
      for (int i = 0; i < NPORTS; i++) begin
        if (commit_i[i] && (waddr_i[i*AW +: AW] == AW'(w))) begin
          hit = 1'b1;
          val = cdata_i[i*WIDTH +: WIDTH];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= val;
    end

    assign words[w*WIDTH +: WIDTH] = word_q;
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_rd
    logic [WIDTH-1:0] rd_d;
    logic [WIDTH-1:0] rd_q;

    always_comb begin
      rd_d = '0;
      for (int w = 0; w < DEPTH; w++) begin
        if (raddr_i[i*AW +: AW] == AW'(w)) rd_d = words[w*WIDTH +: WIDTH];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_q <= '0;
      else if (re_i[i]) rd_q <= rd_d;
    end

    assign rdata_o[i*WIDTH +: WIDTH] = rd_q;
  end

endmodule

// File: rtl/cwm_memory.sv
// Top: shared memory whose same-word write collisions are merged by policy.
// NPORTS and DEPTH are powers of two.
module cwm_memory
  import cwm_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                policy_i,
  input  logic [NPORTS-1:0]         wr_en_i,
  input  logic [NPORTS-1:0]         rd_en_i,
  input  logic [NPORTS*AW-1:0]      addr_i,
  input  logic [NPORTS*WIDTH-1:0]   wdata_i,
  output logic [NPORTS*WIDTH-1:0]   rdata_o,
  output logic [NPORTS-1:0]         wr_ok_o
);

  policy_e                 pol;
  logic [PW-1:0]           ptr;
  logic [NPORTS-1:0]       commit;
  logic [NPORTS*WIDTH-1:0] cdata;
  logic [NPORTS-1:0]       ok_d;
  logic [NPORTS-1:0]       ok_q;
  logic                    clash;
  logic                    adv;

  assign pol = policy_e'(policy_i);
  assign adv = (pol == POL_ROTATE) && clash;

  cwm_rr_ptr #(.NPORTS(NPORTS)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (adv),
    .ptr_o (ptr)
  );

  cwm_resolver #(.NPORTS(NPORTS), .AW(AW), .WIDTH(WIDTH)) u_res (
    .policy_i (pol),
    .we_i     (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .ptr_i    (ptr),
    .commit_o (commit),
    .cdata_o  (cdata),
    .ok_o     (ok_d),
    .clash_o  (clash)
  );

  cwm_store #(.NPORTS(NPORTS), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .waddr_i  (addr_i),
    .cdata_i  (cdata),
    .re_i     (rd_en_i),
    .raddr_i  (addr_i),
    .rdata_o  (rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= '0;
    else        ok_q <= ok_d;
  end

  assign wr_ok_o = ok_q;

endmodule

// File: rtl/cwm_checks.sv
module cwm_checks #(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              policy_i,
  input logic [NPORTS-1:0]       wr_en_i,
  input logic [NPORTS-1:0]       rd_en_i,
  input logic [NPORTS*AW-1:0]    addr_i,
  input logic [NPORTS*WIDTH-1:0] wdata_i,
  input logic [NPORTS*WIDTH-1:0] rdata_o,
  input logic [NPORTS-1:0]       wr_ok_o
);

  // ports writing the same word as port 0 in this cycle
  logic [NPORTS-1:0] grp0;
  always_comb begin
    for (int j = 0; j < NPORTS; j++)
      grp0[j] = wr_en_i[0] && wr_en_i[j] && (addr_i[j*AW +: AW] == addr_i[AW-1:0]);
  end

  a_r9_ok_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((wr_ok_o & ~$past(wr_en_i)) == '0));

  a_r8_sum_all_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == 2'd3) |=> (wr_ok_o == $past(wr_en_i)));

  a_r7_rank_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == 2'd2 && wr_en_i[0]) |=> wr_ok_o[0]);

  a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    ((policy_i == 2'd1 || policy_i == 2'd2) && wr_en_i[0])
      |=> ($countones(wr_ok_o & $past(grp0)) == 1));

  a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i[0] |=> $stable(rdata_o[WIDTH-1:0]));

  if (NPORTS >= 2) begin : g_pair
    a_r5_disagree_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == 2'd0 && grp0[1] &&
       wdata_i[WIDTH-1:0] != wdata_i[2*WIDTH-1:WIDTH])
        |=> (wr_ok_o[1:0] == 2'b00));
  end

endmodule

bind cwm_memory cwm_checks #(.NPORTS(NPORTS), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .policy_i (policy_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .wr_ok_o  (wr_ok_o)
);

// File: tb/tb_cwm_memory.sv
`timescale 1ns/1ps
module tb_cwm_memory;

  localparam int P  = 4;
  localparam int D  = 16;
  localparam int W  = 8;
  localparam int AW = 4;

  logic clk;
  logic rst_n;
  logic [1:0] pol;
  logic [P-1:0] we;
  logic [P-1:0] re;
  logic [P-1:0][AW-1:0] ad;
  logic [P-1:0][W-1:0]  wd;
  logic [P*W-1:0] rdata;
  logic [P-1:0]   wok;

  cwm_memory #(.NPORTS(P), .DEPTH(D), .WIDTH(W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .policy_i (pol),
    .wr_en_i  (we),
    .rd_en_i  (re),
    .addr_i   (ad),
    .wdata_i  (wd),
    .rdata_o  (rdata),
    .wr_ok_o  (wok)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  typedef struct {
    logic [P*W-1:0] rd;
    logic [P-1:0]   ok;
    string          tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state built from the requirements
  logic [W-1:0] mm [D];
  logic [P-1:0][W-1:0] rm;
  int ptr_m;

  task automatic idle();
    we = '0; re = '0; ad = '0; wd = '0; pol = 2'd0;
  endtask

  // driver: called at a negedge with inputs set; pushes the expected item
  task automatic step(input string tag);
    exp_t e;
    logic [W-1:0] nm [D];
    logic [P-1:0] okv;
    bit coll;
    okv = '0; coll = 0;
    for (int w = 0; w < D; w++) nm[w] = mm[w];
    for (int i = 0; i < P; i++) begin
      if (we[i]) begin
        bit lead;
        logic [P-1:0] mask;
        int cnt;
        bit same;
        logic [W-1:0] s;
        lead = 1; mask = '0; cnt = 0; same = 1; s = '0;
        for (int j = 0; j < P; j++) begin
          if (we[j] && ad[j] == ad[i]) begin
            if (j < i) lead = 0;
            mask[j] = 1'b1; cnt++;
            if (wd[j] != wd[i]) same = 0;
            s = s + wd[j];
          end
        end
        if (lead) begin
          case (pol)
            2'd0: if (same) begin okv |= mask; nm[ad[i]] = wd[i]; end
            2'd1: begin
              bit found;
              found = 0;
              if (cnt > 1) coll = 1;
              for (int d = 0; d < P; d++) begin
                int k;
                k = (ptr_m + d) % P;
                if (!found && mask[k]) begin
                  found = 1; okv[k] = 1'b1; nm[ad[i]] = wd[k];
                end
              end
            end
            2'd2: begin okv[i] = 1'b1; nm[ad[i]] = wd[i]; end
            default: begin okv |= mask; nm[ad[i]] = s; end
          endcase
        end
      end
    end
    for (int i = 0; i < P; i++) if (re[i]) rm[i] = mm[ad[i]];
    for (int w = 0; w < D; w++) mm[w] = nm[w];
    if (pol == 2'd1 && coll) ptr_m = (ptr_m + 1) % P;
    e.rd = rm; e.ok = okv; e.tag = tag;
    @(posedge clk);
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compares registered outputs away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rdata !== e.rd) begin
        errors++;
        $display("FAIL %s rdata actual=%h expected=%h", e.tag, rdata, e.rd);
      end
      checks++;
      if (wok !== e.ok) begin
        errors++;
        $display("FAIL %s wr_ok actual=%b expected=%b", e.tag, wok, e.ok);
      end
    end
  end

  task automatic read_all(input string tag);
    for (int b = 0; b < D / P; b++) begin
      idle();
      re = '1;
      for (int i = 0; i < P; i++) ad[i] = AW'(b * P + i);
      step(tag);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    for (int w = 0; w < D; w++) mm[w] = '0;
    rm = '0; ptr_m = 0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    checks++;
    if (rdata !== '0 || wok !== '0) begin
      errors++;
      $display("FAIL R1 reset actual=%h/%b expected=0/0", rdata, wok);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rdata !== '0 || wok !== '0) begin
      errors++;
      $display("FAIL R1 after release actual=%h/%b expected=0/0", rdata, wok);
    end
    read_all("R1");

    // R10 / R4: parallel single writers under every policy
    for (int p = 0; p < 4; p++) begin
      idle();
      pol = 2'(p); we = '1;
      for (int i = 0; i < P; i++) begin
        ad[i] = AW'(p * 4 + i);
        wd[i] = W'(16 * p + i + 1);
      end
      step("R10");
    end
    read_all("R4");

    // R2: all ports read one word, then hold with read enable low
    idle(); re = '1; ad = {AW'(5), AW'(5), AW'(5), AW'(5)}; step("R2");
    idle(); we[3] = 1'b1; ad[3] = AW'(5); wd[3] = 8'h77; pol = 2'd2; step("R2");
    idle(); step("R2");
    idle(); re = '1; ad = {AW'(5), AW'(5), AW'(5), AW'(5)}; step("R2");

    // R3: read during write returns old value, new value next cycle
    idle(); we[0] = 1'b1; ad[0] = AW'(2); wd[0] = 8'hAA; re[1] = 1'b1; ad[1] = AW'(2);
    step("R3");
    idle(); re[1] = 1'b1; ad[1] = AW'(2); step("R3");

    // R5: agreeing and disagreeing writers
    idle(); pol = 2'd0; we = 4'b0111;
    ad = {AW'(0), AW'(7), AW'(7), AW'(7)}; wd = {8'h00, 8'h3C, 8'h3C, 8'h3C};
    step("R5");
    idle(); pol = 2'd0; we = 4'b1010; re[0] = 1'b1;
    ad = {AW'(7), AW'(0), AW'(7), AW'(7)}; wd = {8'h22, 8'h00, 8'h11, 8'h00};
    step("R5");
    idle(); re[2] = 1'b1; ad[2] = AW'(7); step("R5");

    // R6: rotating winner over a chain of collisions
    for (int r = 0; r < 6; r++) begin
      idle(); pol = 2'd1; we = (r % 2 == 0) ? 4'b1111 : 4'b0101;
      for (int i = 0; i < P; i++) begin ad[i] = AW'(12); wd[i] = W'(8'h40 + 4 * r + i); end
      re[3] = 1'b1;
      step("R6");
      idle(); pol = 2'd1; we[1] = 1'b1; ad[1] = AW'(13); wd[1] = W'(r); step("R6");
    end
    idle(); re[0] = 1'b1; ad[0] = AW'(12); step("R6");

    // R7: fixed rank
    idle(); pol = 2'd2; we = 4'b1110;
    for (int i = 0; i < P; i++) begin ad[i] = AW'(9); wd[i] = W'(8'h90 + i); end
    step("R7");
    idle(); pol = 2'd2; we = 4'b1001; re[2] = 1'b1;
    for (int i = 0; i < P; i++) begin ad[i] = AW'(9); wd[i] = W'(8'hE0 + i); end
    step("R7");
    idle(); re[2] = 1'b1; ad[2] = AW'(9); step("R7");

    // R8: sum with wrap, two groups at once
    idle(); pol = 2'd3; we = '1;
    ad = {AW'(11), AW'(11), AW'(11), AW'(11)}; wd = {8'h05, 8'h10, 8'h90, 8'h80};
    step("R8");
    idle(); pol = 2'd3; we = '1;
    ad = {AW'(14), AW'(11), AW'(14), AW'(11)}; wd = {8'hFF, 8'h01, 8'h02, 8'h03};
    re = 4'b0001;
    step("R8");
    idle(); re = 4'b0011; ad[0] = AW'(11); ad[1] = AW'(14); step("R8");

    // R9: mixed traffic, flags checked every cycle
    for (int n = 0; n < 400; n++) begin
      pol = 2'($urandom_range(3));
      for (int i = 0; i < P; i++) begin
        we[i] = 1'($urandom_range(1));
        re[i] = 1'($urandom_range(1));
        ad[i] = AW'($urandom_range(3));
        wd[i] = W'($urandom_range(255));
      end
      if (n % 7 == 0) wd = {wd[0], wd[0], wd[0], wd[0]};
      step("R9");
    end
    read_all("R10");

    idle();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule